// File: doc/BRIEF.md
# Two-Master Shared-Bus Arbiter

This block decides which of two bus masters drives a shared AHB-style bus. Master 0 is the processor and master 1 is a block-copy engine. Each master raises a request line when it wants the bus. The arbiter answers with a one-hot pair of grant lines and reports the current owner on an owner-index output. The fabric uses that owner index to steer the address and control multiplexers.

Arbitration works in two registered stages. The grant stage picks a winner every cycle. The copy engine wins whenever it requests. Otherwise the processor holds the grant, because it is the default owner. The owner stage copies the granted index into the owner output only on a transfer boundary. A boundary is a cycle with the ready line high in which the owner is not partway through a burst. As a result, a grant always leads the ownership change by at least one cycle, and a burst is never split between owners.

Top module: `ahb_pair_arbiter`

## Requirements
- R1: While reset is high, and on the first cycle after it, bus_owner is 0, gnt_cpu is 1 and gnt_dma is 0.
- R2: After each clock edge, gnt_dma equals the value req_dma had before that edge, and gnt_cpu is its complement. req_cpu has no effect on either grant, so the copy engine has priority and the processor is the default.
- R3: Exactly one of gnt_cpu and gnt_dma is high in every cycle.
- R4: At an edge where a boundary was sampled, bus_owner takes the index granted in that cycle (1 when gnt_dma is high, 0 when gnt_cpu is high). At any other edge it keeps its value.
- R5: A boundary requires xfer_ready high and xfer_trans equal to IDLE (2'b00) or NONSEQ (2'b10). With SEQ (2'b11) or BUSY (2'b01), bus_owner does not change, even when ready is high.
- R6: While xfer_ready is low, bus_owner does not change.
- R7: When req_dma falls, the grant returns to the processor after the next edge, and bus_owner returns to 0 at the first boundary that follows.
- R8: A rise of req_dma changes bus_owner no earlier than the second clock edge after the rise, one edge after gnt_dma rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_cpu | input | 1 | Bus request from master 0 (processor) |
| req_dma | input | 1 | Bus request from master 1 (copy engine) |
| xfer_ready | input | 1 | Transfer-complete indication from the selected slave |
| xfer_trans | input | 2 | Transfer type of the current owner: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| gnt_cpu | output | 1 | Grant to master 0 |
| gnt_dma | output | 1 | Grant to master 1 |
| bus_owner | output | 1 | Index of the master that currently owns the bus |

## Verification
The bench builds the block with its default configuration: two masters, a one-bit owner index and a two-bit transfer type. At this size, every combination of the two request lines, the ready line and the four transfer types fits in five input bits. A pseudo-random sweep of several thousand cycles therefore reaches each combination from both owner states and both grant states. An arithmetic two-register model predicts the grant and owner after every edge. Directed sequences then walk through the full hand-over: request, grant, stall on SEQ and BUSY, stall on ready low, hand-over, and hand-back.

// File: rtl/ahb_pair_arb_pkg.sv
package ahb_pair_arb_pkg;

    localparam int NUM_MST = 2;
    localparam int MST_W   = (NUM_MST > 1) ? $clog2(NUM_MST) : 1;
    localparam int TRANS_W = 2;

    typedef logic [MST_W-1:0]   mst_id_t;
    typedef logic [NUM_MST-1:0] mst_vec_t;

    typedef enum logic [TRANS_W-1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    localparam mst_id_t DEFAULT_MST = '0;

    // Highest index among requesters wins; default master when none request.
    function automatic mst_id_t pick_winner(input mst_vec_t req);
        mst_id_t win;
        win = DEFAULT_MST;
        for (int i = 0; i < NUM_MST; i++) begin
            if (req[i]) win = mst_id_t'(i);
        end
        return win;
    endfunction

    // Ownership may move only when the slave is ready and no burst is open.
    function automatic logic at_boundary(input logic ready, input trans_e tr);
        return ready && (tr != TR_SEQ) && (tr != TR_BUSY);
    endfunction

endpackage

// File: rtl/arb_grant_stage.sv
module arb_grant_stage
    import ahb_pair_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mst_vec_t req,
    output mst_id_t  gnt_id
);
    mst_id_t winner;

    always_comb winner = pick_winner(req);

    always_ff @(posedge clk) begin
        if (rst) gnt_id <= DEFAULT_MST;
        else     gnt_id <= winner;
    end
endmodule

// File: rtl/arb_boundary_det.sv
module arb_boundary_det
    import ahb_pair_arb_pkg::*;
(
    input  logic                ready,
    input  logic [TRANS_W-1:0]  trans,
    output logic                boundary
);
    trans_e tr;

    always_comb begin
        tr       = trans_e'(trans);
        boundary = at_boundary(ready, tr);
    end
endmodule

// File: rtl/arb_owner_stage.sv
module arb_owner_stage
    import ahb_pair_arb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    boundary,
    input  mst_id_t gnt_id,
    output mst_id_t owner
);
    always_ff @(posedge clk) begin
        if (rst)           owner <= DEFAULT_MST;
        else if (boundary) owner <= gnt_id;
    end
endmodule

// File: rtl/ahb_pair_arbiter.sv
module ahb_pair_arbiter
    import ahb_pair_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_cpu,
    input  logic               req_dma,
    input  logic               xfer_ready,
    input  logic [TRANS_W-1:0] xfer_trans,
    output logic               gnt_cpu,
    output logic               gnt_dma,
    output logic [MST_W-1:0]   bus_owner
);
    mst_vec_t req_vec;
    mst_vec_t gnt_vec;
    mst_id_t  gnt_id;
    mst_id_t  owner_id;
    logic     boundary;

    assign req_vec = {req_dma, req_cpu};

    arb_grant_stage u_grant (
        .clk    (clk),
        .rst    (rst),
        .req    (req_vec),
        .gnt_id (gnt_id)
    );

    arb_boundary_det u_bnd (
        .ready    (xfer_ready),
        .trans    (xfer_trans),
        .boundary (boundary)
    );

    arb_owner_stage u_owner (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary),
        .gnt_id   (gnt_id),
        .owner    (owner_id)
    );

    for (genvar g = 0; g < NUM_MST; g++) begin : g_gnt_dec
        assign gnt_vec[g] = (gnt_id == mst_id_t'(g));
    end

    assign gnt_cpu   = gnt_vec[0];
    assign gnt_dma   = gnt_vec[1];
    assign bus_owner = owner_id;
endmodule

// File: rtl/ahb_pair_arbiter_chk.sv
module ahb_pair_arbiter_chk
    import ahb_pair_arb_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_dma,
    input logic               xfer_ready,
    input logic [TRANS_W-1:0] xfer_trans,
    input logic               gnt_cpu,
    input logic               gnt_dma,
    input logic [MST_W-1:0]   bus_owner
);
    logic mid_burst;
    assign mid_burst = (xfer_trans == TR_SEQ) || (xfer_trans == TR_BUSY);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (bus_owner == '0 && gnt_cpu && !gnt_dma)); // R1

    AST_GNT_TRACKS_REQ: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (gnt_dma == $past(req_dma))); // R2

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $countones({gnt_cpu, gnt_dma}) == 1); // R3

    AST_OWNER_TAKES_GNT: assert property (@(posedge clk) disable iff (rst)
        (xfer_ready && !mid_burst) |=> (bus_owner == MST_W'($past(gnt_dma)))); // R4

    AST_NO_SPLIT_BURST: assert property (@(posedge clk) disable iff (rst)
        mid_burst |=> $stable(bus_owner)); // R5

    AST_HOLD_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        !xfer_ready |=> $stable(bus_owner)); // R6

    AST_GNT_LEADS_OWNER: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_owner[0]) |-> $past(gnt_dma)); // R8
endmodule

bind ahb_pair_arbiter ahb_pair_arbiter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_dma    (req_dma),
    .xfer_ready (xfer_ready),
    .xfer_trans (xfer_trans),
    .gnt_cpu    (gnt_cpu),
    .gnt_dma    (gnt_dma),
    .bus_owner  (bus_owner)
);

// File: tb/ahb_pair_arbiter_tb.sv
`timescale 1ns/1ps
module ahb_pair_arbiter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_cpu = 1'b0;
    logic       req_dma = 1'b0;
    logic       xfer_ready = 1'b1;
    logic [1:0] xfer_trans = 2'b00;
    logic       gnt_cpu;
    logic       gnt_dma;
    logic [0:0] bus_owner;

    int n_chk = 0;
    int n_bad = 0;
    int m_gnt = 0;
    int m_own = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ahb_pair_arbiter u_dut (
        .clk        (clk),
        .rst        (rst),
        .req_cpu    (req_cpu),
        .req_dma    (req_dma),
        .xfer_ready (xfer_ready),
        .xfer_trans (xfer_trans),
        .gnt_cpu    (gnt_cpu),
        .gnt_dma    (gnt_dma),
        .bus_owner  (bus_owner)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle of inputs, advance the model, compare all outputs.
    task automatic step(input bit c, input bit d, input bit r, input logic [1:0] t);
        int bnd;
        @(negedge clk);
        req_cpu = c; req_dma = d; xfer_ready = r; xfer_trans = t;
        @(posedge clk);
        #1;
        bnd = (r && t != 2'b11 && t != 2'b01) ? 1 : 0;
        if (bnd == 1) m_own = m_gnt;
        m_gnt = d ? 1 : 0;
        chk("R2 gnt_dma", int'(gnt_dma), m_gnt);
        chk("R2 gnt_cpu", int'(gnt_cpu), 1 - m_gnt);
        chk("R3 onehot", int'(gnt_cpu) + int'(gnt_dma), 1);
        chk("R4 owner", int'(bus_owner), m_own);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 owner in reset", int'(bus_owner), 0);
        chk("R1 gnt_cpu in reset", int'(gnt_cpu), 1);
        chk("R1 gnt_dma in reset", int'(gnt_dma), 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 owner after reset", int'(bus_owner), 0);
        chk("R1 gnt_cpu after reset", int'(gnt_cpu), 1);

        // R8: request rise; grant next edge, owner one edge later
        step(1, 1, 1, 2'b00);
        chk("R8 owner not yet moved", int'(bus_owner), 0);
        chk("R8 grant up", int'(gnt_dma), 1);
        step(1, 1, 1, 2'b10);
        chk("R8 owner moved on second edge", int'(bus_owner), 1);

        // R5: processor burst holds ownership through SEQ and BUSY
        step(0, 0, 1, 2'b00);
        step(1, 1, 1, 2'b10);  // owner -> 0 at this boundary, grant -> 1
        chk("R7 owner back to cpu", int'(bus_owner), 0);
        step(1, 1, 1, 2'b11);
        chk("R5 SEQ holds", int'(bus_owner), 0);
        step(1, 1, 1, 2'b01);
        chk("R5 BUSY holds", int'(bus_owner), 0);
        step(1, 1, 1, 2'b11);
        chk("R5 SEQ holds again", int'(bus_owner), 0);
        // R6: not ready holds even with IDLE
        step(1, 1, 0, 2'b00);
        chk("R6 ready low holds", int'(bus_owner), 0);
        step(1, 1, 0, 2'b10);
        chk("R6 ready low holds NONSEQ", int'(bus_owner), 0);
        step(1, 1, 1, 2'b00);
        chk("R5 IDLE boundary hands over", int'(bus_owner), 1);

        // R7: request drops; grant back next edge, owner at next boundary
        step(1, 0, 1, 2'b11);
        chk("R7 grant back to cpu", int'(gnt_cpu), 1);
        chk("R7 owner held in burst", int'(bus_owner), 1);
        step(1, 0, 0, 2'b00);
        chk("R7 owner held ready low", int'(bus_owner), 1);
        step(0, 0, 1, 2'b10);
        chk("R7 owner returns", int'(bus_owner), 0);

        // R2: processor request has no effect on grant
        step(0, 0, 1, 2'b00);
        chk("R2 default grant no requests", int'(gnt_cpu), 1);
        step(1, 0, 1, 2'b00);
        chk("R2 cpu request only", int'(gnt_cpu), 1);
        step(0, 1, 1, 2'b00);
        chk("R2 dma request only", int'(gnt_dma), 1);

        // Sweep of all input combinations from every state
        lf = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[6], lf[5] ^ lf[9], |lf[2:0] | lf[11], lf[4:3]);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule